// File: doc/BRIEF.md
# Three-Wire Serial Word EEPROM Model

This block is a synthesizable slave that stands in for a small serial EEPROM holding 16-bit words. A host drives a serial clock, a chip select and a serial data input; the block returns data on a single serial output. Everything runs on the system clock. The serial clock is a plain input that is sampled there, and a low-to-high change seen between two system clock edges counts as one serial clock edge. The data input is taken on that edge while chip select is high.

Every command begins with a start bit of 1. A two-bit opcode follows, then the word address, then 16 data bits for the two commands that carry a word. Reads, single-word writes and single-word erases are selected by the opcode. Opcode 00 takes its real meaning from the top two address bits, which select write-enable, write-disable, erase of every word, or write of every word. Programming commands take effect when chip select falls after a complete frame, and only while writing is enabled. After such a command the host raises chip select again and watches the output: it reads 0 while the programming time counts down and 1 once it has elapsed. A separate debug port returns any stored word combinationally. The host paces the serial clock, so the serial link has no back-pressure, and the debug port is a plain address-to-data path.

Top module: `tw_eeprom`

## Requirements
- R1: After reset every word holds 16'hFFFF, writing is disabled and the serial output is 0.
- R2: A frame is a start bit of 1, a 2-bit opcode, ADDR_W address bits and, for word-carrying commands, 16 data bits, all sent MSB first on serial clock rising edges while chip select is high. Zero bits received before the start bit are ignored, and so are start bits received while programming is in progress.
- R3: The opcode field decodes as 10 = read, 01 = write word, 11 = erase word and 00 = extended. For an extended command the top two address bits decode as 11 = enable writes, 00 = disable writes, 10 = erase every word and 01 = write every word (16 data bits follow). The remaining address bits are don't-care.
- R4: For a read, the output is 0 after the rising edge that takes the last address bit. Each later rising edge presents the next bit of the addressed word, MSB first. The output returns to 0 after the LSB.
- R5: A write stores the 16-bit data at the address. An erase sets that word to 16'hFFFF and leaves every other word unchanged.
- R6: Erase-all sets every word to 16'hFFFF. Write-all stores the given data in every word.
- R7: While writing is disabled, write, erase, erase-all and write-all are fully decoded but change no word and start no programming time. The output stays 0 when chip select is raised again.
- R8: Chip select low returns the decoder to idle. A programming command takes effect only when chip select falls after its last bit, so a frame cut short has no effect.
- R9: After an executed programming command, chip select low is taken at system clock edge P0. If the host then holds chip select high with the decoder idle, the output is 0 through BUSY_CYCLES edges after P0 and becomes 1 from edge P0+BUSY_CYCLES on.
- R10: The debug port returns the word at the debug address combinationally, with no effect on the serial side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sk_i | input | 1 | Serial clock from the host, sampled on clk_i |
| cs_i | input | 1 | Chip select, active high |
| di_i | input | 1 | Serial data into the device |
| do_o | output | 1 | Serial data out: read bits or the ready status |
| dbg_addr_i | input | ADDR_W | Debug read address |
| dbg_data_o | output | 16 | Word stored at dbg_addr_i |

## Verification
The bench builds the small variant, with ADDR_W = 6 for 64 words and a BUSY_CYCLES of 8. With 64 words, every address can be written with its own arithmetic pattern, read back serially and checked through the debug port in one run. The short programming time makes it cheap to check the exact edge where the ready status flips after every write. The lock, abort, leading-zero and whole-array commands are then run against a store whose every word has a known value.

// File: rtl/tw_pkg.sv
package tw_pkg;

  localparam logic [1:0] OPC_EXT   = 2'b00;
  localparam logic [1:0] OPC_WRITE = 2'b01;
  localparam logic [1:0] OPC_READ  = 2'b10;
  localparam logic [1:0] OPC_ERASE = 2'b11;

  localparam logic [1:0] EXT_LOCK  = 2'b00;
  localparam logic [1:0] EXT_FILL  = 2'b01;
  localparam logic [1:0] EXT_WIPE  = 2'b10;
  localparam logic [1:0] EXT_OPEN  = 2'b11;

  typedef enum logic [2:0] {
    PG_NONE,
    PG_WRITE,
    PG_ERASE,
    PG_WIPE_ALL,
    PG_FILL_ALL,
    PG_OPEN,
    PG_LOCK
  } prog_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPC,
    ST_ADDR,
    ST_DATA,
    ST_READ,
    ST_ARMED
  } dec_state_e;

  function automatic prog_op_e classify(input logic [1:0] opc, input logic [1:0] ext);
    prog_op_e r;
    case (opc)
      OPC_WRITE: r = PG_WRITE;
      OPC_ERASE: r = PG_ERASE;
      OPC_EXT: begin
        case (ext)
          EXT_OPEN: r = PG_OPEN;
          EXT_WIPE: r = PG_WIPE_ALL;
          EXT_FILL: r = PG_FILL_ALL;
          default:  r = PG_LOCK;
        endcase
      end
      default:   r = PG_NONE;
    endcase
    return r;
  endfunction

  function automatic logic is_storage_op(input prog_op_e op);
    return (op == PG_WRITE) || (op == PG_ERASE) || (op == PG_WIPE_ALL) || (op == PG_FILL_ALL);
  endfunction

endpackage

// File: rtl/tw_busy_timer.sv
module tw_busy_timer #(
  parameter int BUSY_CYCLES = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(BUSY_CYCLES);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (start_i) begin
      cnt_q <= LOAD;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign busy_o = (cnt_q != '0);

  AST_BUSY_AFTER_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> busy_o); // R9
  AST_BUSY_COUNTS_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !start_i) |=> (cnt_q == CNT_W'($past(cnt_q) - 1'b1))); // R9

endmodule

// File: rtl/tw_word_store.sv
module tw_word_store
  import tw_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  prog_op_e          op_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic [ADDR_W-1:0] dbg_addr_i,
  output logic [DATA_W-1:0] dbg_data_o
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [DATA_W-1:0] ERASED = {DATA_W{1'b1}};

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [DEPTH-1:0]  upd;
  logic [DATA_W-1:0] new_word;

  always_comb begin
    new_word = data_i;
    if (op_i == PG_ERASE || op_i == PG_WIPE_ALL) new_word = ERASED;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_sel
    logic hit;
    assign hit    = (addr_i == ADDR_W'(g));
    assign upd[g] = we_i && (((op_i == PG_WRITE || op_i == PG_ERASE) && hit) ||
                             op_i == PG_WIPE_ALL || op_i == PG_FILL_ALL);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= ERASED;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (upd[i]) mem_q[i] <= new_word;
      end
    end
  end

  assign rd_data_o  = mem_q[rd_addr_i];
  assign dbg_data_o = mem_q[dbg_addr_i];

  AST_WORD_WRITTEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && op_i == PG_WRITE) |=> (mem_q[$past(addr_i)] == $past(data_i))); // R5
  AST_WIPE_REACHES_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && op_i == PG_WIPE_ALL) |=> (mem_q[0] == ERASED && mem_q[DEPTH-1] == ERASED)); // R6

endmodule

// File: rtl/tw_cmd_decoder.sv
module tw_cmd_decoder
  import tw_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sk_i,
  input  logic              cs_i,
  input  logic              di_i,
  input  logic              busy_i,
  input  logic [DATA_W-1:0] word_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              rd_bit_o,
  output logic              rd_active_o,
  output logic              idle_o,
  output logic              start_o,
  output logic              commit_o,
  output prog_op_e          op_o,
  output logic [DATA_W-1:0] data_o
);
  localparam int MAXW = (DATA_W > ADDR_W) ? DATA_W : ADDR_W;
  localparam int CW   = $clog2(MAXW + 1);
  localparam logic [CW-1:0] ADDR_LAST = CW'(ADDR_W - 1);
  localparam logic [CW-1:0] DATA_LAST = CW'(DATA_W - 1);
  localparam logic [CW-1:0] DATA_CNT  = CW'(DATA_W);

  dec_state_e        state_q;
  logic              sk_q;
  logic [CW-1:0]     cnt_q;
  logic [1:0]        opc_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  prog_op_e          op_q;
  logic              rd_bit_q;

  logic              rise;
  logic [ADDR_W-1:0] addr_full;
  logic [1:0]        ext_bits;
  prog_op_e          op_dec;
  logic [CW-1:0]     bit_idx;

  assign rise      = sk_i && !sk_q && cs_i;
  assign addr_full = {addr_q[ADDR_W-2:0], di_i};
  assign ext_bits  = addr_full[ADDR_W-1 -: 2];
  assign op_dec    = classify(opc_q, ext_bits);
  assign bit_idx   = DATA_LAST - cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      sk_q     <= 1'b0;
      cnt_q    <= '0;
      opc_q    <= '0;
      addr_q   <= '0;
      data_q   <= '0;
      op_q     <= PG_NONE;
      rd_bit_q <= 1'b0;
    end else begin
      sk_q <= sk_i;
      if (!cs_i) begin
        state_q  <= ST_IDLE;
        rd_bit_q <= 1'b0;
      end else if (rise) begin
        case (state_q)
          ST_IDLE: begin
            if (di_i && !busy_i) begin
              state_q <= ST_OPC;
              cnt_q   <= '0;
            end
          end
          ST_OPC: begin
            opc_q <= {opc_q[0], di_i};
            if (cnt_q == CW'(1)) begin
              state_q <= ST_ADDR;
              cnt_q   <= '0;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_ADDR: begin
            addr_q <= addr_full;
            if (cnt_q == ADDR_LAST) begin
              cnt_q <= '0;
              if (opc_q == OPC_READ) begin
                state_q  <= ST_READ;
                rd_bit_q <= 1'b0;
              end else begin
                op_q <= op_dec;
                if (op_dec == PG_WRITE || op_dec == PG_FILL_ALL) state_q <= ST_DATA;
                else state_q <= ST_ARMED;
              end
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_DATA: begin
            data_q <= {data_q[DATA_W-2:0], di_i};
            if (cnt_q == DATA_LAST) state_q <= ST_ARMED;
            else cnt_q <= cnt_q + 1'b1;
          end
          ST_READ: begin
            if (cnt_q < DATA_CNT) begin
              rd_bit_q <= word_i[bit_idx];
              cnt_q    <= cnt_q + 1'b1;
            end else begin
              rd_bit_q <= 1'b0;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign addr_o      = addr_q;
  assign rd_bit_o    = rd_bit_q;
  assign rd_active_o = (state_q == ST_READ);
  assign idle_o      = (state_q == ST_IDLE);
  assign start_o     = rise && (state_q == ST_IDLE) && di_i && !busy_i;
  assign commit_o    = !cs_i && (state_q == ST_ARMED);
  assign op_o        = op_q;
  assign data_o      = data_q;

  AST_CS_LOW_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_i |=> idle_o); // R8
  AST_BUSY_BLOCKS_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && idle_o) |=> idle_o); // R2
  AST_READ_LEAD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise && state_q == ST_ADDR && cnt_q == ADDR_LAST && opc_q == OPC_READ)
      |=> (rd_active_o && !rd_bit_o)); // R4

endmodule

// File: rtl/tw_eeprom.sv
module tw_eeprom
  import tw_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int BUSY_CYCLES = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sk_i,
  input  logic              cs_i,
  input  logic              di_i,
  output logic              do_o,
  input  logic [ADDR_W-1:0] dbg_addr_i,
  output logic [15:0]       dbg_data_o
);
  localparam int DATA_W = 16;

  logic              busy;
  logic [DATA_W-1:0] word_rd;
  logic [ADDR_W-1:0] cmd_addr;
  logic              rd_bit;
  logic              rd_active;
  logic              dec_idle;
  logic              start_seen;
  logic              commit;
  prog_op_e          cmd_op;
  logic [DATA_W-1:0] cmd_data;
  logic              wen_q;
  logic              status_q;
  logic              exec;

  tw_cmd_decoder #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sk_i       (sk_i),
    .cs_i       (cs_i),
    .di_i       (di_i),
    .busy_i     (busy),
    .word_i     (word_rd),
    .addr_o     (cmd_addr),
    .rd_bit_o   (rd_bit),
    .rd_active_o(rd_active),
    .idle_o     (dec_idle),
    .start_o    (start_seen),
    .commit_o   (commit),
    .op_o       (cmd_op),
    .data_o     (cmd_data)
  );

  assign exec = commit && wen_q && is_storage_op(cmd_op);

  tw_word_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (exec),
    .op_i      (cmd_op),
    .addr_i    (cmd_addr),
    .data_i    (cmd_data),
    .rd_addr_i (cmd_addr),
    .rd_data_o (word_rd),
    .dbg_addr_i(dbg_addr_i),
    .dbg_data_o(dbg_data_o)
  );

  tw_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(exec),
    .busy_o (busy)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wen_q    <= 1'b0;
      status_q <= 1'b0;
    end else begin
      if (commit && cmd_op == PG_OPEN) wen_q <= 1'b1;
      if (commit && cmd_op == PG_LOCK) wen_q <= 1'b0;
      if (exec) status_q <= 1'b1;
      else if (start_seen) status_q <= 1'b0;
    end
  end

  always_comb begin
    if (rd_active) do_o = rd_bit;
    else if (cs_i && dec_idle && status_q) do_o = !busy;
    else do_o = 1'b0;
  end

  AST_STATUS_NEEDS_ENABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_q) |-> $past(wen_q)); // R7
  AST_READY_ONLY_WHEN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (do_o && !rd_active) |-> (!busy && cs_i)); // R9

endmodule

// File: tb/tw_eeprom_tb.sv
`timescale 1ns/1ps
module tw_eeprom_tb;
  localparam int AW    = 6;
  localparam int DEPTH = 1 << AW;
  localparam int BUSY  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sk = 1'b0;
  logic cs = 1'b0;
  logic di = 1'b0;
  logic dout;
  logic [AW-1:0] dbg_addr = '0;
  logic [15:0] dbg_data;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  tw_eeprom #(.ADDR_W(AW), .BUSY_CYCLES(BUSY)) u_dut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .sk_i      (sk),
    .cs_i      (cs),
    .di_i      (di),
    .do_o      (dout),
    .dbg_addr_i(dbg_addr),
    .dbg_data_o(dbg_data)
  );

  function automatic logic [15:0] pat(input int a);
    return 16'(a * 16'h0301) ^ 16'hA55A;
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic peek(input int a, output logic [15:0] v);
    @(negedge clk);
    dbg_addr = AW'(a);
    #1 v = dbg_data;
  endtask

  task automatic bit_io(input logic b, output logic r);
    @(negedge clk);
    di = b;
    sk = 1'b0;
    @(negedge clk);
    sk = 1'b1;
    @(negedge clk);
    @(negedge clk);
    r = dout;
  endtask

  task automatic cs_on();
    @(negedge clk);
    sk = 1'b0;
    cs = 1'b1;
  endtask

  task automatic cs_off();
    @(negedge clk);
    sk = 1'b0;
    cs = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic send_cmd(input logic [1:0] opc, input logic [AW-1:0] addr,
                          input bit has_data, input logic [15:0] data);
    logic r;
    cs_on();
    bit_io(1'b1, r);
    for (int i = 1; i >= 0; i--) bit_io(opc[i], r);
    for (int i = AW - 1; i >= 0; i--) bit_io(addr[i], r);
    if (has_data) for (int i = 15; i >= 0; i--) bit_io(data[i], r);
  endtask

  // Ends a programming frame, then polls the status output at the exact edges.
  task automatic finish_prog(input bit expect_status, input string req);
    @(negedge clk);
    sk = 1'b0;
    cs = 1'b0;
    @(negedge clk);
    cs = 1'b1;
    repeat (BUSY - 1) @(negedge clk);
    check({req, " status busy"}, {15'd0, dout}, 16'd0);
    @(negedge clk);
    check({req, " status ready"}, {15'd0, dout}, expect_status ? 16'd1 : 16'd0);
    cs_off();
  endtask

  task automatic read_word(input int a, input int nlead, output logic lead, output logic [15:0] w);
    logic r;
    cs_on();
    for (int i = 0; i < nlead; i++) bit_io(1'b0, r);
    bit_io(1'b1, r);
    bit_io(1'b1, r);
    bit_io(1'b0, r);
    for (int i = AW - 1; i >= 0; i--) bit_io(AW'(a) >> i, r);
    lead = r;
    for (int i = 15; i >= 0; i--) begin
      bit_io(1'b0, r);
      w[i] = r;
    end
    cs_off();
  endtask

  localparam logic [AW-1:0] X_OPEN = AW'(2'b11) << (AW - 2);
  localparam logic [AW-1:0] X_LOCK = '0;
  localparam logic [AW-1:0] X_WIPE = AW'(2'b10) << (AW - 2);
  localparam logic [AW-1:0] X_FILL = AW'(2'b01) << (AW - 2);

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] v;
    logic [15:0] w;
    logic lead;
    logic r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    check("R1 reset output", {15'd0, dout}, 16'd0);
    for (int a = 0; a < DEPTH; a++) begin
      peek(a, v);
      check("R1 reset word", v, 16'hFFFF);
    end

    // R7: write while locked leaves word and gives no status
    send_cmd(2'b01, AW'(5), 1'b1, 16'h1234);
    finish_prog(1'b0, "R7");
    peek(5, v);
    check("R7 locked write", v, 16'hFFFF);

    // R3: enable writes through the extended opcode
    send_cmd(2'b00, X_OPEN, 1'b0, 16'h0);
    cs_off();

    // R5 and R9: write every address with its own pattern
    for (int a = 0; a < DEPTH; a++) begin
      send_cmd(2'b01, AW'(a), 1'b1, pat(a));
      finish_prog(1'b1, "R9");
      peek(a, v);
      check("R5 R10 write word", v, pat(a));
    end

    // R4 and R2: serial read-back with 0 to 2 leading zeros
    for (int a = 0; a < DEPTH; a++) begin
      read_word(a, a % 3, lead, w);
      check("R4 leading zero", {15'd0, lead}, 16'd0);
      check("R2 R3 R4 read word", w, pat(a));
    end

    // R5: single erase leaves neighbours
    send_cmd(2'b11, AW'(10), 1'b0, 16'h0);
    finish_prog(1'b1, "R9");
    peek(10, v);
    check("R5 erase word", v, 16'hFFFF);
    peek(9, v);
    check("R5 erase neighbour low", v, pat(9));
    peek(11, v);
    check("R5 erase neighbour high", v, pat(11));

    // R8: frame cut short inside the data field
    cs_on();
    bit_io(1'b1, r);
    bit_io(1'b0, r);
    bit_io(1'b1, r);
    for (int i = AW - 1; i >= 0; i--) bit_io(AW'(3) >> i, r);
    for (int i = 0; i < 8; i++) bit_io(1'b0, r);
    cs_off();
    peek(3, v);
    check("R8 aborted write", v, pat(3));
    read_word(3, 0, lead, w);
    check("R8 decoder idle after abort", w, pat(3));

    // R6: write every word
    send_cmd(2'b00, X_FILL, 1'b1, 16'h5A3C);
    finish_prog(1'b1, "R9");
    for (int a = 0; a < DEPTH; a++) begin
      peek(a, v);
      check("R6 fill all", v, 16'h5A3C);
    end

    // R7: lock, then erase-all and single erase must not change anything
    send_cmd(2'b00, X_LOCK, 1'b0, 16'h0);
    cs_off();
    send_cmd(2'b00, X_WIPE, 1'b0, 16'h0);
    finish_prog(1'b0, "R7");
    send_cmd(2'b11, AW'(0), 1'b0, 16'h0);
    finish_prog(1'b0, "R7");
    for (int a = 0; a < DEPTH; a++) begin
      peek(a, v);
      check("R7 locked wipe", v, 16'h5A3C);
    end

    // R6: enable again and erase every word
    send_cmd(2'b00, X_OPEN, 1'b0, 16'h0);
    cs_off();
    send_cmd(2'b00, X_WIPE, 1'b0, 16'h0);
    finish_prog(1'b1, "R9");
    for (int a = 0; a < DEPTH; a++) begin
      peek(a, v);
      check("R6 wipe all", v, 16'hFFFF);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule